// File: doc/BRIEF.md
# Double-Precision to Unsigned Integer Converter

This unit takes one IEEE-754 binary64 operand and turns it into an unsigned integer of either 32 or 64 bits. The result, the invalid flag and the inexact flag appear on registered outputs one clock after the operand is presented. A new operand may be applied on every cycle.

The result width is normally 32 bits. A 64-bit result is produced only when the core is in its 64-bit mode and the operation also asks for the wide size. The rounding direction comes from a per-operation override, but only when that override is enabled and the operand is a register operand. In every other case the global rounding-control field chooses the direction.

A value that cannot be held in the destination, including NaN and infinity, raises the invalid flag. When invalid is masked, the result saturates to the all-ones value of the destination width.

Top module: `fp64_to_uint`

## Requirements
- R1: While reset is held, the outputs are zero. After reset, each output reflects the inputs sampled at the previous rising clock edge, so the latency is exactly one cycle.
- R2: The destination is 64 bits wide only when `long_mode_i` and `req_wide_i` are both 1. Any other combination converts to 32 bits.
- R3: A 32-bit result is placed in bits [31:0] of `res_o`, and bits [63:32] are zero.
- R4: The rounding mode is taken from `rc_ovr_i` when `rc_ovr_en_i` and `src_is_reg_i` are both 1. Otherwise it is taken from `rc_glob_i`.
- R5: The rounding-mode encoding is 00 = to nearest with ties to even, 01 = toward minus infinity, 10 = toward plus infinity, 11 = toward zero. An inexact value is rounded in the selected direction.
- R6: `pe_o` is 1 when the operand has a nonzero fractional part and the conversion is not invalid.
- R7: `inv_o` is 1 when the rounded value lies outside the range 0 to 2^w-1, where w is the destination width.
- R8: A NaN (quiet or signalling) or an infinity of either sign always sets `inv_o`.
- R9: When the conversion is invalid and `inv_mask_i` is 1, the result is 2^w-1 (0x00000000FFFFFFFF for 32 bits, all ones for 64 bits). When `inv_mask_i` is 0, the result is zero.
- R10: `inv_o` and `pe_o` are never 1 at the same time. An invalid result suppresses the inexact flag.
- R11: A negative operand whose rounded value is zero is valid and gives zero. For example, -0.3 rounded to nearest gives 0 with `pe_o` set, and -0.0 gives 0 with no flags.
- R12: Denormals and other nonzero magnitudes below 1 give 0 or 1, depending on the rounding direction, and set `pe_o` unless the result is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 64 | binary64 operand |
| long_mode_i | input | 1 | 64-bit mode is active |
| req_wide_i | input | 1 | Operation requests a 64-bit result |
| src_is_reg_i | input | 1 | Operand comes from a register |
| rc_ovr_en_i | input | 1 | Per-operation rounding override enable |
| rc_ovr_i | input | 2 | Per-operation rounding mode |
| rc_glob_i | input | 2 | Global rounding mode |
| inv_mask_i | input | 1 | Invalid exception is masked |
| res_o | output | 64 | Converted result, zero-extended |
| inv_o | output | 1 | Invalid flag |
| pe_o | output | 1 | Inexact (precision) flag |

## Verification
The following properties are checked on every cycle:
- NaN and infinity are always flagged invalid.
- The two flags are mutually exclusive.
- The upper half of the result is zero whenever the 64-bit size was not in effect.
- A masked invalid result saturates, and an unmasked invalid result is zero.
- A valid negative operand gives zero.

The numeric result itself is shown only by the bench's sweep. That sweep covers every quarter step from -10 to +10, with all four rounding modes reached through each rounding source and each width setting. Directed cases add the 2^32 and 2^64 boundaries, ties at those boundaries, denormals and NaN payloads.

// File: rtl/fp2u_pkg.sv
package fp2u_pkg;
    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_DOWN    = 2'b01,
        RM_UP      = 2'b10,
        RM_ZERO    = 2'b11
    } rmode_e;
endpackage

// File: rtl/fp2u_rmode_sel.sv
module fp2u_rmode_sel
    import fp2u_pkg::*;
(
    input  logic       ovr_en_i,
    input  logic       src_is_reg_i,
    input  logic [1:0] ovr_i,
    input  logic [1:0] glob_i,
    output rmode_e     mode_o
);
    // The override counts only for register operands (R4).
    assign mode_o = rmode_e'((ovr_en_i && src_is_reg_i) ? ovr_i : glob_i);
endmodule

// File: rtl/fp2u_align.sv
module fp2u_align #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    parameter int OUT_W  = 64
) (
    input  logic [EXP_W+FRAC_W:0] op_i,
    output logic                  sign_o,
    output logic                  special_o,
    output logic                  big_o,
    output logic                  guard_o,
    output logic                  sticky_o,
    output logic [OUT_W-1:0]      mag_o
);
    localparam int MANT_W  = FRAC_W + 1;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int WIDE_W  = MANT_W + OUT_W;
    localparam int MAX_LSH = OUT_W - MANT_W;

    logic [EXP_W-1:0]  expo;
    logic [MANT_W-1:0] mant;
    logic [WIDE_W-1:0] wide;
    int                sh;
    int                rsh;

    assign expo      = op_i[EXP_W+FRAC_W-1:FRAC_W];
    assign sign_o    = op_i[EXP_W+FRAC_W];
    assign special_o = &expo;
    assign mant      = {|expo, op_i[FRAC_W-1:0]};

    always_comb begin
        sh       = ((expo == '0) ? 1 : int'(expo)) - BIAS - FRAC_W;
        rsh      = 0;
        wide     = '0;
        big_o    = 1'b0;
        guard_o  = 1'b0;
        sticky_o = 1'b0;
        mag_o    = '0;
        if (sh >= 0) begin
            // Integer already; only a range question remains.
            big_o = (sh > MAX_LSH);
            if (!big_o) mag_o = OUT_W'(mant) << sh;
        end else begin
            // Shifts past OUT_W leave guard clear and only sticky.
            rsh      = (-sh > OUT_W) ? OUT_W : -sh;
            wide     = {mant, {OUT_W{1'b0}}} >> rsh;
            mag_o    = OUT_W'(wide[WIDE_W-1:OUT_W]);
            guard_o  = wide[OUT_W-1];
            sticky_o = |wide[OUT_W-2:0];
        end
    end
endmodule

// File: rtl/fp2u_round.sv
module fp2u_round
    import fp2u_pkg::*;
#(
    parameter int OUT_W    = 64,
    parameter int NARROW_W = 32
) (
    input  logic             sign_i,
    input  logic             special_i,
    input  logic             big_i,
    input  logic             guard_i,
    input  logic             sticky_i,
    input  logic [OUT_W-1:0] mag_i,
    input  rmode_e           mode_i,
    input  logic             wide_i,
    input  logic             mask_i,
    output logic [OUT_W-1:0] res_o,
    output logic             inv_o,
    output logic             pe_o
);
    logic           inc;
    logic           inexact;
    logic           over;
    logic [OUT_W:0] sum;
    logic [OUT_W-1:0] sat;

    assign inexact = guard_i | sticky_i;

    always_comb begin
        unique case (mode_i)
            RM_NEAREST: inc = guard_i & (sticky_i | mag_i[0]);
            RM_DOWN:    inc = sign_i & inexact;
            RM_UP:      inc = !sign_i & inexact;
            RM_ZERO:    inc = 1'b0;
            default:    inc = 1'b0;
        endcase
        sum = {1'b0, mag_i} + (OUT_W+1)'(inc);
        if (sign_i)      over = big_i | (sum != '0);
        else if (wide_i) over = big_i | sum[OUT_W];
        else             over = big_i | (|sum[OUT_W:NARROW_W]);
        inv_o = special_i | over;
        sat   = wide_i ? {OUT_W{1'b1}} : OUT_W'({NARROW_W{1'b1}});
        res_o = inv_o ? (mask_i ? sat : '0) : sum[OUT_W-1:0];
        pe_o  = inexact & !inv_o;
    end
endmodule

// File: rtl/fp64_to_uint.sv
module fp64_to_uint
    import fp2u_pkg::*;
#(
    parameter int EXP_W    = 11,
    parameter int FRAC_W   = 52,
    parameter int OUT_W    = 64,
    parameter int NARROW_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [EXP_W+FRAC_W:0] op_i,
    input  logic                  long_mode_i,
    input  logic                  req_wide_i,
    input  logic                  src_is_reg_i,
    input  logic                  rc_ovr_en_i,
    input  logic [1:0]            rc_ovr_i,
    input  logic [1:0]            rc_glob_i,
    input  logic                  inv_mask_i,
    output logic [OUT_W-1:0]      res_o,
    output logic                  inv_o,
    output logic                  pe_o
);
    rmode_e           mode;
    logic             sign, special, big, guard, sticky;
    logic [OUT_W-1:0] mag;
    logic [OUT_W-1:0] res_d;
    logic             inv_d, pe_d;
    logic             wide_eff;

    assign wide_eff = long_mode_i & req_wide_i;

    fp2u_rmode_sel u_sel (
        .ovr_en_i     (rc_ovr_en_i),
        .src_is_reg_i (src_is_reg_i),
        .ovr_i        (rc_ovr_i),
        .glob_i       (rc_glob_i),
        .mode_o       (mode)
    );

    fp2u_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W)) u_align (
        .op_i      (op_i),
        .sign_o    (sign),
        .special_o (special),
        .big_o     (big),
        .guard_o   (guard),
        .sticky_o  (sticky),
        .mag_o     (mag)
    );

    fp2u_round #(.OUT_W(OUT_W), .NARROW_W(NARROW_W)) u_round (
        .sign_i    (sign),
        .special_i (special),
        .big_i     (big),
        .guard_i   (guard),
        .sticky_i  (sticky),
        .mag_i     (mag),
        .mode_i    (mode),
        .wide_i    (wide_eff),
        .mask_i    (inv_mask_i),
        .res_o     (res_d),
        .inv_o     (inv_d),
        .pe_o      (pe_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_o <= '0;
            inv_o <= 1'b0;
            pe_o  <= 1'b0;
        end else begin
            res_o <= res_d;
            inv_o <= inv_d;
            pe_o  <= pe_d;
        end
    end
endmodule

// File: rtl/fp2u_check.sv
module fp2u_check (
    input logic        clk,
    input logic        rst_n,
    input logic [63:0] op_i,
    input logic        long_mode_i,
    input logic        req_wide_i,
    input logic        inv_mask_i,
    input logic [63:0] res_o,
    input logic        inv_o,
    input logic        pe_o
);
    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    p_special_invalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        armed && ($past(op_i[62:52]) == 11'h7FF) |-> inv_o);

    p_flag_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(inv_o && pe_o));

    p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !$past(long_mode_i && req_wide_i) |-> (res_o[63:32] == 32'h0));

    p_sat_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        armed && inv_o && $past(inv_mask_i) && $past(long_mode_i && req_wide_i)
        |-> (res_o == 64'hFFFF_FFFF_FFFF_FFFF));

    p_unmasked_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        armed && inv_o && !$past(inv_mask_i) |-> (res_o == 64'h0));

    p_neg_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !inv_o && $past(op_i[63]) |-> (res_o == 64'h0));
endmodule

bind fp64_to_uint fp2u_check u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_i        (op_i),
    .long_mode_i (long_mode_i),
    .req_wide_i  (req_wide_i),
    .inv_mask_i  (inv_mask_i),
    .res_o       (res_o),
    .inv_o       (inv_o),
    .pe_o        (pe_o)
);

// File: tb/sim_fp64_to_uint.sv
module sim_fp64_to_uint;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] op = '0;
    logic        lm = 1'b0, rw = 1'b0, isreg = 1'b0, oen = 1'b0, mask = 1'b1;
    logic [1:0]  ovr = 2'b00, glob = 2'b00;
    logic [63:0] res;
    logic        inv, pe;
    int          n_run = 0, n_fail = 0;
    bit          done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp64_to_uint u0 (
        .clk(clk), .rst_n(rst_n), .op_i(op), .long_mode_i(lm), .req_wide_i(rw),
        .src_is_reg_i(isreg), .rc_ovr_en_i(oen), .rc_ovr_i(ovr), .rc_glob_i(glob),
        .inv_mask_i(mask), .res_o(res), .inv_o(inv), .pe_o(pe)
    );

    task automatic cmp(input string tag, input logic [63:0] er, input logic ei, input logic ep);
        n_run++;
        if (res !== er || inv !== ei || pe !== ep) begin
            n_fail++;
            $display("FAIL %s: got res=%h inv=%b pe=%b, expected res=%h inv=%b pe=%b",
                     tag, res, inv, pe, er, ei, ep);
        end
    endtask

    task automatic run(input string tag, input logic [63:0] v, input logic l, input logic w,
                       input logic r, input logic en, input logic [1:0] o, input logic [1:0] g,
                       input logic m, input logic [63:0] er, input logic ei, input logic ep);
        @(negedge clk);
        op = v; lm = l; rw = w; isreg = r; oen = en; ovr = o; glob = g; mask = m;
        @(posedge clk);
        @(negedge clk);
        cmp(tag, er, ei, ep);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] big32, big64, top64;
        op = $realtobits(5.0);
        repeat (3) @(negedge clk);
        cmp("R1 reset state", 64'h0, 1'b0, 1'b0);
        rst_n = 1'b1;

        // R1: latency of one edge.
        run("R1 first", $realtobits(7.0), 0, 0, 0, 0, 2'd0, 2'd0, 1, 64'd7, 0, 0);
        @(negedge clk);
        op = $realtobits(9.0);
        #1 cmp("R1 holds before edge", 64'd7, 0, 0);
        @(posedge clk); @(negedge clk);
        cmp("R1 after edge", 64'd9, 0, 0);

        // R5/R4/R2/R3/R6/R11/R12: quarter-step sweep.
        for (int k = -40; k <= 40; k++) begin
            for (int md = 0; md < 4; md++) begin
                for (int src = 0; src < 3; src++) begin
                    for (int cfg = 0; cfg < 4; cfg++) begin
                        int mag, ip, fr, rr;
                        bit neg, up, einv, epe;
                        logic [63:0] eres, sat;
                        logic [1:0] o, g;
                        bit en, r;
                        neg = (k < 0); mag = neg ? -k : k;
                        ip = mag / 4; fr = mag % 4;
                        case (md)
                            0: up = (fr > 2) || (fr == 2 && (ip % 2 == 1));
                            1: up = neg && fr != 0;
                            2: up = !neg && fr != 0;
                            default: up = 0;
                        endcase
                        rr = ip + (up ? 1 : 0);
                        einv = neg && rr != 0;
                        epe = (fr != 0) && !einv;
                        sat = (cfg == 3) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
                        eres = einv ? sat : (neg ? 64'h0 : 64'(rr));
                        case (src)
                            0: begin en = 0; r = 1; o = ~2'(md); g = 2'(md); end
                            1: begin en = 1; r = 1; o = 2'(md); g = ~2'(md); end
                            default: begin en = 1; r = 0; o = ~2'(md); g = 2'(md); end
                        endcase
                        run("R5 sweep", $realtobits(real'(k) / 4.0), cfg[1], cfg[0], r, en, o, g,
                            1, eres, einv, epe);
                    end
                end
            end
        end

        big32 = 64'h1_0000_0000;
        // R7, R2, R9, R10
        run("R7 max32", $realtobits(4294967295.0), 0, 0, 1, 0, 0, 0, 1, 64'hFFFF_FFFF, 0, 0);
        run("R7 2^32 narrow", $realtobits(4294967296.0), 0, 0, 1, 0, 0, 0, 1, 64'hFFFF_FFFF, 1, 0);
        run("R2 2^32 wide", $realtobits(4294967296.0), 1, 1, 1, 0, 0, 0, 1, big32, 0, 0);
        run("R2 wide ignored no mode", $realtobits(4294967296.0), 0, 1, 1, 0, 0, 0, 1, 64'hFFFF_FFFF, 1, 0);
        run("R2 mode without request", $realtobits(4294967296.0), 1, 0, 1, 0, 0, 0, 1, 64'hFFFF_FFFF, 1, 0);
        run("R10 tie to 2^32", $realtobits(4294967295.5), 0, 0, 1, 0, 0, 0, 1, 64'hFFFF_FFFF, 1, 0);
        run("R6 tie truncated", $realtobits(4294967295.5), 0, 0, 1, 0, 0, 2'd3, 1, 64'hFFFF_FFFF, 0, 1);
        run("R7 tie wide", $realtobits(4294967295.5), 1, 1, 1, 0, 0, 0, 1, big32, 0, 1);
        big64 = $realtobits(2.0 ** 64);
        top64 = $realtobits(18446744073709549568.0);
        run("R9 2^64 sat", big64, 1, 1, 1, 0, 0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0);
        run("R7 top64", top64, 1, 1, 1, 0, 0, 0, 1, 64'hFFFF_FFFF_FFFF_F800, 0, 0);
        run("R7 2^53-1", $realtobits(9007199254740991.0), 1, 1, 1, 0, 0, 0, 1, 64'h1F_FFFF_FFFF_FFFF, 0, 0);
        // R8, R9
        run("R8 qnan", 64'h7FF8_0000_0000_0000, 1, 1, 1, 0, 0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0);
        run("R9 snan unmasked", 64'h7FF0_0000_0000_0001, 0, 0, 1, 0, 0, 0, 0, 64'h0, 1, 0);
        run("R8 +inf", 64'h7FF0_0000_0000_0000, 0, 0, 1, 0, 0, 0, 1, 64'hFFFF_FFFF, 1, 0);
        run("R8 -inf", 64'hFFF0_0000_0000_0000, 1, 1, 1, 0, 0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0);
        run("R9 unmasked huge", big64, 1, 1, 1, 0, 0, 0, 0, 64'h0, 1, 0);
        // R11, R12
        run("R11 -0.0", 64'h8000_0000_0000_0000, 0, 0, 1, 0, 0, 0, 1, 64'h0, 0, 0);
        run("R11 -0.3", $realtobits(-0.3), 0, 0, 1, 0, 0, 0, 1, 64'h0, 0, 1);
        run("R12 denorm up", 64'h1, 0, 0, 1, 0, 0, 2'd2, 1, 64'd1, 0, 1);
        run("R12 denorm nearest", 64'h1, 0, 0, 1, 0, 0, 2'd0, 1, 64'd0, 0, 1);
        run("R12 denorm zero", 64'h1, 0, 0, 1, 0, 0, 2'd3, 1, 64'd0, 0, 1);
        run("R12 -denorm down", 64'h8000_0000_0000_0001, 0, 0, 1, 0, 0, 2'd1, 1, 64'hFFFF_FFFF, 1, 0);
        run("R12 -denorm up", 64'h8000_0000_0000_0001, 0, 0, 1, 0, 0, 2'd2, 1, 64'h0, 0, 1);
        // R4: override ignored for memory operand.
        run("R4 mem ignores override", $realtobits(2.5), 0, 0, 0, 1, 2'd2, 2'd3, 1, 64'd2, 0, 1);
        run("R4 reg uses override", $realtobits(2.5), 0, 0, 1, 1, 2'd2, 2'd3, 1, 64'd3, 0, 1);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule